// File: doc/BRIEF.md
# Combined Audio/Video Byte Interleaver

This block feeds one byte stream to a decoder that takes both audio and video. It draws bytes from a video FIFO and an audio FIFO. Both FIFOs are show-ahead: the data is on the bus whenever the FIFO is not empty, and a pop consumes it. The block places the bytes into a repeating slot pattern of `ratio` video slots and then one audio slot. The decoder paces the transfer through two active-low request inputs, one for each stream. Every byte that leaves the block is marked by the valid strobe of its own stream.

The arbitration is asymmetric. An audio slot that cannot be used for audio goes to video, provided a video byte is ready and video is requested, and the pattern then restarts. A video slot is never handed to audio. In a video slot the pattern waits until a video byte can move. The interleaver runs only while the combined-mode enable is high.

Top module: `av_interleaver`

## Requirements
- R1: After synchronous reset, both valid strobes are low and the pattern starts at video slot 0.
- R2: With both streams always ready and requested, the output repeats `ratio` video bytes and then one audio byte.
- R3: A `ratio` of 0 behaves exactly like a `ratio` of 1.
- R4: In an audio slot, when the audio FIFO is not empty and `aud_req_n` is low, one audio byte is popped and the pattern returns to video slot 0.
- R5: In an audio slot, when the audio FIFO is empty or `aud_req_n` is high, a video byte is popped in its place if the video FIFO is not empty and `vid_req_n` is low, and the pattern returns to video slot 0.
- R6: An audio byte is never popped in a video slot. In a video slot with no video byte available or requested, nothing is popped and the slot is held.
- R7: In an audio slot where neither stream can move, nothing is popped and the slot is held.
- R8: A stream is popped only while its request input is low. A request tied low is always honoured.
- R9: The cycle after a pop, exactly one strobe goes high: `vid_valid` for a video pop, `aud_valid` for an audio pop. `out_data` then carries the byte that was popped.
- R10: While `combined_en` is low, nothing is popped, no strobe rises, and the pattern is reset to video slot 0.
- R11: No FIFO is ever popped while its empty flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| combined_en | input | 1 | Combined-mode enable |
| ratio | input | RATIO_W | Number of video slots per audio slot (0 is treated as 1) |
| vid_empty | input | 1 | Video FIFO empty flag |
| vid_data | input | DATA_W | Video FIFO head byte |
| vid_pop | output | 1 | Pop the video FIFO |
| aud_empty | input | 1 | Audio FIFO empty flag |
| aud_data | input | DATA_W | Audio FIFO head byte |
| aud_pop | output | 1 | Pop the audio FIFO |
| vid_req_n | input | 1 | Decoder video request, active low |
| aud_req_n | input | 1 | Decoder audio request, active low |
| out_data | output | DATA_W | Output byte |
| vid_valid | output | 1 | Output byte is video |
| aud_valid | output | 1 | Output byte is audio |

## Verification
The hardest case is an audio slot in which audio is blocked and video is ready at the same time. The counter must first be walked through every video slot before the fill rule can apply. To reach this case, the bench sweeps `ratio` from 0 to 5 across sixteen stimulus modes. Each mode frees or pseudo-randomly toggles a different subset of the two empty flags and the two requests. A bench-side slot model then predicts every pop and every strobe. Some modes also drop the enable now and then, so that the pattern restarts from the middle of a sequence.

// File: rtl/av_il_pkg.sv
package av_il_pkg;

    localparam int DEF_DATA_W  = 8;
    localparam int DEF_RATIO_W = 4;

    typedef enum logic [1:0] {
        GNT_NONE  = 2'd0,
        GNT_VIDEO = 2'd1,
        GNT_AUDIO = 2'd2
    } grant_e;

    typedef struct packed {
        grant_e grant;
        logic   fill;     // video byte placed in an audio slot
    } arb_res_t;

    function automatic arb_res_t arbitrate(input logic en,
                                           input logic at_audio,
                                           input logic vid_ok,
                                           input logic aud_ok);
        arb_res_t r;
        r.grant = GNT_NONE;
        r.fill  = 1'b0;
        if (en) begin
            if (!at_audio) begin
                if (vid_ok) r.grant = GNT_VIDEO;
            end else if (aud_ok) begin
                r.grant = GNT_AUDIO;
            end else if (vid_ok) begin
                r.grant = GNT_VIDEO;
                r.fill  = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/av_il_slot_seq.sv
module av_il_slot_seq #(
    parameter int RATIO_W = av_il_pkg::DEF_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               step_video,
    input  logic               step_wrap,
    output logic [RATIO_W-1:0] slot_idx,
    output logic               at_audio
);
    logic [RATIO_W-1:0] eff_ratio;

    always_comb begin
        eff_ratio = (ratio == '0) ? RATIO_W'(1) : ratio;
        at_audio  = (slot_idx >= eff_ratio);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            slot_idx <= '0;
        end else if (step_wrap) begin
            slot_idx <= '0;
        end else if (step_video) begin
            slot_idx <= slot_idx + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/av_il_arbiter.sv
module av_il_arbiter
    import av_il_pkg::*;
(
    input  logic en,
    input  logic at_audio,
    input  logic vid_empty,
    input  logic aud_empty,
    input  logic vid_req_n,
    input  logic aud_req_n,
    output logic vid_pop,
    output logic aud_pop,
    output logic step_video,
    output logic step_wrap
);
    arb_res_t res;

    always_comb begin
        res        = arbitrate(en, at_audio, !vid_empty && !vid_req_n,
                               !aud_empty && !aud_req_n);
        vid_pop    = (res.grant == GNT_VIDEO);
        aud_pop    = (res.grant == GNT_AUDIO);
        step_video = vid_pop && !at_audio;
        step_wrap  = at_audio && (res.grant != GNT_NONE);
    end
endmodule

// File: rtl/av_il_out_stage.sv
module av_il_out_stage #(
    parameter int DATA_W = av_il_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_pop,
    input  logic              aud_pop,
    input  logic [DATA_W-1:0] vid_data,
    input  logic [DATA_W-1:0] aud_data,
    output logic [DATA_W-1:0] out_data,
    output logic              vid_valid,
    output logic              aud_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            vid_valid <= 1'b0;
            aud_valid <= 1'b0;
        end else begin
            vid_valid <= vid_pop;
            aud_valid <= aud_pop;
            if (vid_pop)      out_data <= vid_data;
            else if (aud_pop) out_data <= aud_data;
        end
    end
endmodule

// File: rtl/av_interleaver.sv
module av_interleaver #(
    parameter int DATA_W  = av_il_pkg::DEF_DATA_W,
    parameter int RATIO_W = av_il_pkg::DEF_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               combined_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               vid_empty,
    input  logic [DATA_W-1:0]  vid_data,
    output logic               vid_pop,
    input  logic               aud_empty,
    input  logic [DATA_W-1:0]  aud_data,
    output logic               aud_pop,
    input  logic               vid_req_n,
    input  logic               aud_req_n,
    output logic [DATA_W-1:0]  out_data,
    output logic               vid_valid,
    output logic               aud_valid
);
    logic               at_audio;
    logic               step_video;
    logic               step_wrap;
    logic [RATIO_W-1:0] slot_idx;

    av_il_slot_seq #(.RATIO_W(RATIO_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .en         (combined_en),
        .ratio      (ratio),
        .step_video (step_video),
        .step_wrap  (step_wrap),
        .slot_idx   (slot_idx),
        .at_audio   (at_audio)
    );

    av_il_arbiter arb_i (
        .en         (combined_en),
        .at_audio   (at_audio),
        .vid_empty  (vid_empty),
        .aud_empty  (aud_empty),
        .vid_req_n  (vid_req_n),
        .aud_req_n  (aud_req_n),
        .vid_pop    (vid_pop),
        .aud_pop    (aud_pop),
        .step_video (step_video),
        .step_wrap  (step_wrap)
    );

    av_il_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst       (rst),
        .vid_pop   (vid_pop),
        .aud_pop   (aud_pop),
        .vid_data  (vid_data),
        .aud_data  (aud_data),
        .out_data  (out_data),
        .vid_valid (vid_valid),
        .aud_valid (aud_valid)
    );
endmodule

// File: rtl/av_interleaver_chk.sv
module av_interleaver_chk #(
    parameter int RATIO_W = av_il_pkg::DEF_RATIO_W
) (
    input logic               clk,
    input logic               rst,
    input logic               combined_en,
    input logic               vid_empty,
    input logic               aud_empty,
    input logic               vid_req_n,
    input logic               aud_req_n,
    input logic               vid_pop,
    input logic               aud_pop,
    input logic               vid_valid,
    input logic               aud_valid,
    input logic               at_audio,
    input logic [RATIO_W-1:0] slot_idx
);
    // R9
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vid_pop, aud_pop}));
    // R11
    vid_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        vid_pop |-> !vid_empty);
    // R11
    aud_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        aud_pop |-> !aud_empty);
    // R8
    vid_req_chk: assert property (@(posedge clk) disable iff (rst)
        vid_pop |-> !vid_req_n);
    // R8
    aud_req_chk: assert property (@(posedge clk) disable iff (rst)
        aud_pop |-> !aud_req_n);
    // R6
    aud_only_in_aslot_chk: assert property (@(posedge clk) disable iff (rst)
        aud_pop |-> at_audio);
    // R6
    vslot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (combined_en && !at_audio && !vid_pop) |=> $stable(slot_idx));
    // R9
    vid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        vid_pop |=> (vid_valid && !aud_valid));
    // R9
    aud_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        aud_pop |=> (aud_valid && !vid_valid));
    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !combined_en |-> (!vid_pop && !aud_pop));
    // R10
    disabled_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !combined_en |=> (slot_idx == '0));
endmodule

bind av_interleaver av_interleaver_chk #(.RATIO_W(RATIO_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .combined_en (combined_en),
    .vid_empty   (vid_empty),
    .aud_empty   (aud_empty),
    .vid_req_n   (vid_req_n),
    .aud_req_n   (aud_req_n),
    .vid_pop     (vid_pop),
    .aud_pop     (aud_pop),
    .vid_valid   (vid_valid),
    .aud_valid   (aud_valid),
    .at_audio    (at_audio),
    .slot_idx    (slot_idx)
);

// File: tb/av_interleaver_tb.sv
module av_interleaver_tb_top;
    localparam int DW = 8;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          combined_en;
    logic [RW-1:0] ratio;
    logic          vid_empty, aud_empty, vid_req_n, aud_req_n;
    logic [DW-1:0] vid_data, aud_data, out_data;
    logic          vid_pop, aud_pop, vid_valid, aud_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    av_interleaver #(.DATA_W(DW), .RATIO_W(RW)) dut_i (
        .clk(clk), .rst(rst), .combined_en(combined_en), .ratio(ratio),
        .vid_empty(vid_empty), .vid_data(vid_data), .vid_pop(vid_pop),
        .aud_empty(aud_empty), .aud_data(aud_data), .aud_pop(aud_pop),
        .vid_req_n(vid_req_n), .aud_req_n(aud_req_n),
        .out_data(out_data), .vid_valid(vid_valid), .aud_valid(aud_valid)
    );

    // bench model state
    int          mslot;
    int          vseq, aseq;
    logic [15:0] lfsr = 16'hACE1;
    logic        exp_vv, exp_av;
    logic [DW-1:0] exp_d;
    string       exp_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic check_outputs();
        chk(vid_valid === exp_vv, exp_tag, "vid_valid", int'(vid_valid), int'(exp_vv));
        chk(aud_valid === exp_av, exp_tag, "aud_valid", int'(aud_valid), int'(exp_av));
        if (exp_vv || exp_av)
            chk(out_data === exp_d, exp_tag, "out_data", int'(out_data), int'(exp_d));
    endtask

    // one cycle: check previous result, drive new inputs, predict
    task automatic step(input int n, input bit en, input bit ve, input bit ae,
                        input bit vr, input bit ar);
        int  neff;
        bit  at_aud, vok, aok, pv, pa;
        string tag;
        @(negedge clk);
        check_outputs();
        combined_en = en;
        vid_empty   = ve;
        aud_empty   = ae;
        vid_req_n   = vr;
        aud_req_n   = ar;
        vid_data    = DW'(vseq & 8'h7F);
        aud_data    = DW'(8'h80 | (aseq & 8'h7F));
        #1;
        neff   = (n == 0) ? 1 : n;                  // R3
        at_aud = (mslot >= neff);
        vok    = !ve && !vr;
        aok    = !ae && !ar;
        pv = 0; pa = 0;
        if (!en) begin
            tag = "R10"; mslot = 0;
        end else if (!at_aud) begin
            if (vok) begin pv = 1; mslot++; tag = (n == 0) ? "R3" : "R2"; end
            else tag = "R6";
        end else if (aok) begin
            pa = 1; mslot = 0; tag = "R4";
        end else if (vok) begin
            pv = 1; mslot = 0; tag = "R5";
        end else begin
            tag = "R7";
        end
        chk(vid_pop === pv, (ve || vr) ? "R8" : tag, "vid_pop", int'(vid_pop), int'(pv));
        chk(aud_pop === pa, (ae || ar) ? "R11" : tag, "aud_pop", int'(aud_pop), int'(pa));
        exp_vv  = pv;
        exp_av  = pa;
        exp_d   = pv ? DW'(vseq & 8'h7F) : (pa ? DW'(8'h80 | (aseq & 8'h7F)) : exp_d);
        exp_tag = (pv || pa) ? "R9" : tag;
        if (pv) vseq++;
        if (pa) aseq++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        combined_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mslot = 0;
        exp_vv = 0; exp_av = 0; exp_tag = "R1";
    endtask

    initial begin
        rst = 1'b1; combined_en = 0; ratio = '0;
        vid_empty = 1; aud_empty = 1; vid_req_n = 1; aud_req_n = 1;
        vid_data = '0; aud_data = '0;
        vseq = 0; aseq = 0; mslot = 0; exp_d = '0;
        do_reset();
        @(negedge clk);
        // R1: strobes low after reset
        chk(vid_valid === 1'b0, "R1", "vid_valid", int'(vid_valid), 0);
        chk(aud_valid === 1'b0, "R1", "aud_valid", int'(aud_valid), 0);

        // R2: directed pattern ratio 4, all ready: V V V V A repeated
        ratio = RW'(4);
        for (int i = 0; i < 10; i++) begin
            step(4, 1, 0, 0, 0, 0);
            chk(aud_pop === ((i % 5) == 4), "R2", "pattern aud_pop",
                int'(aud_pop), int'((i % 5) == 4));
        end
        step(4, 0, 1, 1, 1, 1);
        step(4, 0, 1, 1, 1, 1);

        // sweep ratio x stimulus modes
        for (int n = 0; n <= 5; n++) begin
            do_reset();
            ratio = RW'(n);
            for (int m = 0; m < 16; m++) begin
                for (int c = 0; c < 30; c++) begin
                    bit en, ve, ae, vr, ar;
                    ve = m[0] ? lfsr[1] : 1'b0;
                    ae = m[1] ? lfsr[4] : 1'b0;
                    vr = m[2] ? lfsr[7] : 1'b0;
                    ar = m[3] ? (lfsr[9] | lfsr[11]) : 1'b0;
                    en = (m >= 12) ? ((c % 11) != 7) : 1'b1;
                    step(n, en, ve, ae, vr, ar);
                end
            end
            step(n, 0, 1, 1, 1, 1);
            step(n, 0, 1, 1, 1, 1);
        end
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule